// File: doc/BRIEF.md
# GPIO Bank Register File with Per-Bit Write Masks

This block holds the pin-control state for a bank of general-purpose I/O ports. The bank is reached over a plain 32-bit register bus. Each port covers eight pins and has four byte-wide registers: a mode register that hands each pin to GPIO control, a direction register, an output-value register, and a read-only input register. The input register shows the pad levels after a two-stage synchronizer.

The three writable registers can each be written in two ways. A plain write replaces the whole byte. A masked write goes to an alias address. In the alias write, the upper byte of the low half-word selects which pins change, so software can change a single pin without first reading the register. Reads return the register byte, with zeros above it. The pads are modelled as separate output-value, output-enable and input vectors. A pad is driven only when its pin is under GPIO control and set as an output.

Top module: `gpio_mw_bank`

## Requirements
- R1: Reset is synchronous and active low. After reset every mode, direction and output-value bit is 0, so `pad_oe` and `pad_out` are all zero and every register reads 0.
- R2: A plain write changes the addressed register in the next clock edge. The register takes `bus_wdata[7:0]` in full, and bits 31:8 of the write word have no effect.
- R3: A masked write adds 0x80 to the plain address. Bits 15:8 of the write word are a per-pin mask and bits 7:0 are the new values. Only pins whose mask bit is 1 change, and a zero mask leaves the register as it was.
- R4: The byte address is decoded as follows. Bits 1:0 must be 0. Bits 3:2 select the port, and the port index must be below `NUM_PORTS`. Bits 6:4 select the register: 0 is mode, 1 is direction, 2 is output value and 3 is input. Bit 7 selects the masked alias.
- R5: `pad_oe` of a pin is 1 exactly when both its mode bit and its direction bit are 1. `pad_out` follows the output-value register. Pin n of port p is vector bit 8*p+n.
- R6: The input register shows `pad_in` delayed by two clock edges. A write to it, plain or masked, is ignored.
- R7: `bus_rdata` is combinational on `bus_addr`, and bits 31:8 always read 0. An alias address reads the plain register. An unmapped address (register field 4 to 7, a nonzero bits 1:0, or a port index out of range) reads 0, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte address for both read and write |
| bus_wdata | input | 32 | Write word |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | 8*NUM_PORTS | Asynchronous pad levels |
| pad_out | output | 8*NUM_PORTS | Pad output values |
| pad_oe | output | 8*NUM_PORTS | Pad output enables |

## Verification
The bench targets masked writes whose mask is partial or empty. A design that ignores the mask would overwrite pins it should leave alone, and one that inverts the mask would change the wrong nibble. It writes with junk in the upper word and to the unmapped register field 4 and beyond. A decoder that dropped address bit 6 would then clobber the mode register of port 0. It writes to the read-only input register, both plain and through the alias, and reads back zero. It also changes the pads and samples one and two edges later, so a synchronizer with one stage or with three stages shows up. Last, it sets pins with mode and direction in mixed combinations, so that an output enable taken from the direction bit alone gives a wrong `pad_oe`.

// File: rtl/gpio_mw_pkg.sv
// Shared definitions for the GPIO bank register file.
// Assumes byte-wide port registers and a fixed masked-write word layout:
// mask in bits 15:8, values in bits 7:0.
package gpio_mw_pkg;

    localparam int PORT_PINS = 8;

    typedef enum logic [2:0] {
        REG_MODE = 3'd0,
        REG_DIR  = 3'd1,
        REG_VAL  = 3'd2,
        REG_SYNC = 3'd3
    } reg_kind_e;

    // Replace only the bits selected by sel_mask.
    function automatic logic [PORT_PINS-1:0] merge_bits(
        input logic [PORT_PINS-1:0] old_bits,
        input logic [PORT_PINS-1:0] sel_mask,
        input logic [PORT_PINS-1:0] new_bits
    );
        return (old_bits & ~sel_mask) | (new_bits & sel_mask);
    endfunction

endpackage

// File: rtl/gpio_mw_decode.sv
// Address decoder for the GPIO bank.
// Splits a byte address into alias flag, register kind and port index, and
// flags whether the address maps to a real register.
// Assumes 8-bit byte addresses, with at most four ports selected by bits 3:2.
module gpio_mw_decode
    import gpio_mw_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    localparam int PIDX_W   = 2
) (
    input  logic [7:0]        addr,
    output logic              hit,
    output logic              alias_sel,
    output reg_kind_e         kind,
    output logic [PIDX_W-1:0] port_idx
);
    logic port_ok;

    // Port index range check; trivial when all four slots exist.
    generate
        if (NUM_PORTS >= 4) begin : g_full
            assign port_ok = 1'b1;
        end else begin : g_part
            assign port_ok = (int'(addr[3:2]) < NUM_PORTS);
        end
    endgenerate

    // Field split and map check.
    always_comb begin
        alias_sel = addr[7];
        kind      = reg_kind_e'(addr[6:4]);
        port_idx  = addr[3:2];
        hit       = (addr[1:0] == 2'b00) && !addr[6] && port_ok;
    end

endmodule

// File: rtl/gpio_mw_port.sv
// State for one eight-pin port: mode, direction and output-value bytes, plus
// the two-stage input synchronizer.
// Assumes the parent has already applied the mask (all ones for a plain write).
module gpio_mw_port
    import gpio_mw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_sel,
    input  reg_kind_e            kind,
    input  logic [PORT_PINS-1:0] wmask,
    input  logic [PORT_PINS-1:0] wval,
    input  logic [PORT_PINS-1:0] pins_in,
    output logic [PORT_PINS-1:0] mode_q,
    output logic [PORT_PINS-1:0] dir_q,
    output logic [PORT_PINS-1:0] val_q,
    output logic [PORT_PINS-1:0] sync_q
);
    logic [PORT_PINS-1:0] meta_q;

    // Writable control bytes; the input byte has no write path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            dir_q  <= '0;
            val_q  <= '0;
        end else if (wr_sel) begin
            case (kind)
                REG_MODE: mode_q <= merge_bits(mode_q, wmask, wval);
                REG_DIR:  dir_q  <= merge_bits(dir_q,  wmask, wval);
                REG_VAL:  val_q  <= merge_bits(val_q,  wmask, wval);
                default:  ;
            endcase
        end
    end

    // Two-flop synchronizer for the pad levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= pins_in;
            sync_q <= meta_q;
        end
    end

endmodule

// File: rtl/gpio_mw_bank.sv
// GPIO bank register file with plain and masked write paths.
// Decodes bus accesses, updates one port per write, serves combinational
// reads and drives the pad vectors.
// Assumes a single-cycle write strobe and a read address held steady for a cycle.
module gpio_mw_bank
    import gpio_mw_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    localparam int NPINS    = NUM_PORTS * PORT_PINS,
    localparam int PIDX_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr_en,
    input  logic [7:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe
);
    logic              dec_hit;
    logic              dec_alias;
    reg_kind_e         dec_kind;
    logic [PIDX_W-1:0] dec_port;
    logic [PORT_PINS-1:0] wr_mask;
    logic [PORT_PINS-1:0] mode_b [NUM_PORTS];
    logic [PORT_PINS-1:0] dir_b  [NUM_PORTS];
    logic [PORT_PINS-1:0] val_b  [NUM_PORTS];
    logic [PORT_PINS-1:0] sync_b [NUM_PORTS];
    logic [PORT_PINS-1:0] rd_byte;

    gpio_mw_decode #(.NUM_PORTS(NUM_PORTS)) dec_i (
        .addr      (bus_addr),
        .hit       (dec_hit),
        .alias_sel (dec_alias),
        .kind      (dec_kind),
        .port_idx  (dec_port)
    );

    // A plain write selects every pin; an alias write uses the carried mask.
    assign wr_mask = dec_alias ? bus_wdata[15:8] : {PORT_PINS{1'b1}};

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            gpio_mw_port port_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_sel  (bus_wr_en && dec_hit && (int'(dec_port) == p)),
                .kind    (dec_kind),
                .wmask   (wr_mask),
                .wval    (bus_wdata[7:0]),
                .pins_in (pad_in[p*PORT_PINS +: PORT_PINS]),
                .mode_q  (mode_b[p]),
                .dir_q   (dir_b[p]),
                .val_q   (val_b[p]),
                .sync_q  (sync_b[p])
            );
            // Pad drive: output only under GPIO mode with direction set.
            assign pad_oe [p*PORT_PINS +: PORT_PINS] = mode_b[p] & dir_b[p];
            assign pad_out[p*PORT_PINS +: PORT_PINS] = val_b[p];
        end
    endgenerate

    // Read mux: alias addresses see the plain register, unmapped reads zero.
    always_comb begin
        rd_byte = '0;
        if (dec_hit) begin
            case (dec_kind)
                REG_MODE: rd_byte = mode_b[dec_port];
                REG_DIR:  rd_byte = dir_b[dec_port];
                REG_VAL:  rd_byte = val_b[dec_port];
                REG_SYNC: rd_byte = sync_b[dec_port];
                default:  rd_byte = '0;
            endcase
        end
    end

    assign bus_rdata = {{(32-PORT_PINS){1'b0}}, rd_byte};

endmodule

// File: rtl/gpio_mw_bank_chk.sv
// Property checker for gpio_mw_bank, attached through bind.
// Observes only the ports of the bank.
module gpio_mw_bank_chk #(
    parameter int NUM_PORTS = 4,
    localparam int NPINS    = NUM_PORTS * 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr_en,
    input logic [7:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic [31:0]      bus_rdata,
    input logic [NPINS-1:0] pad_in,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_oe
);
    // R1: the first cycle after reset shows idle pads.
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pad_oe == '0 && pad_out == '0));

    // R5: pads move only after a write.
    assert_pads_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(bus_wr_en)) |-> ($stable(pad_oe) && $stable(pad_out)));

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
            // R2: a plain output-value write lands in full.
            assert_plain_val_R2: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(bus_wr_en) && $past(bus_addr) == 8'(8'h20 + 4*p))
                |-> (pad_out[p*8 +: 8] == $past(bus_wdata[7:0])));

            // R3: unmasked pins keep their value across an alias write.
            assert_mask_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(bus_wr_en) && $past(bus_addr) == 8'(8'hA0 + 4*p))
                |-> (((pad_out[p*8 +: 8] ^ $past(pad_out[p*8 +: 8]))
                      & ~$past(bus_wdata[15:8])) == 8'h00));

            // R6: a steady pad reads back after two edges.
            assert_sync_in_R6: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(rst_n, 2) && bus_addr == 8'(8'h30 + 4*p)
                 && $stable(pad_in) && $past(pad_in) == $past(pad_in, 2))
                |-> (bus_rdata[7:0] == pad_in[p*8 +: 8]));
        end
    endgenerate

endmodule

bind gpio_mw_bank gpio_mw_bank_chk #(.NUM_PORTS(NUM_PORTS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr_en (bus_wr_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe)
);

// File: tb/gpio_mw_bank_tb.sv
module gpio_mw_bank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int NV = 11;

    // Each vector: write address, write word, read-back address, expected read.
    typedef struct packed {
        logic [7:0]  waddr;
        logic [31:0] wdata;
        logic [7:0]  raddr;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{8'h00, 32'hFFFF_FFA5, 8'h00, 32'h0000_00A5},  // R2 upper bits ignored
        '{8'h80, 32'h0000_0F30, 8'h80, 32'h0000_00A0},  // R3 low nibble masked; R7 alias read
        '{8'h14, 32'h0000_003C, 8'h14, 32'h0000_003C},  // R4 dir port 1
        '{8'h94, 32'h0000_C0FF, 8'h14, 32'h0000_00FC},  // R3 set top two bits
        '{8'h2C, 32'h0000_0081, 8'h2C, 32'h0000_0081},  // R4 val port 3
        '{8'hAC, 32'h0000_00FF, 8'h2C, 32'h0000_0081},  // R3 empty mask
        '{8'h30, 32'h0000_00FF, 8'h30, 32'h0000_0000},  // R6 input write ignored
        '{8'hB0, 32'h0000_FFFF, 8'h30, 32'h0000_0000},  // R6 alias write ignored
        '{8'h40, 32'h0000_00FF, 8'h00, 32'h0000_00A0},  // R7 unmapped write no effect
        '{8'h01, 32'h0000_0055, 8'h00, 32'h0000_00A0},  // R7 misaligned no effect
        '{8'h04, 32'h0000_00F0, 8'h04, 32'h0000_00F0}   // R4 mode port 1
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr_en = 1'b0;
    logic [7:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NP*8-1:0] pad_in = '0;
    logic [NP*8-1:0] pad_out;
    logic [NP*8-1:0] pad_oe;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_mw_bank #(.NUM_PORTS(NP)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic compare(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        compare(req, bus_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int r = 0; r < 4; r++)
            for (int p = 0; p < NP; p++)
                read_chk("R1 reset reg", 8'(16*r + 4*p), 32'h0);
        compare("R1 reset pad_oe", pad_oe, '0);
        compare("R1 reset pad_out", pad_out, '0);

        for (int i = 0; i < NV; i++) begin
            bus_write(VECS[i].waddr, VECS[i].wdata);
            read_chk($sformatf("vector %0d", i), VECS[i].raddr, VECS[i].exp);
        end

        // R5 pads: p1 mode F0 & dir FC, p3 val 81, p0 dir 0
        #1;
        compare("R5 pad_oe mixed", pad_oe, 32'h0000_F000);
        compare("R5 pad_out", pad_out, 32'h8100_0000);
        bus_write(8'h8C, 32'h0000_0101);
        bus_write(8'h1C, 32'h0000_0001);
        #1;
        compare("R5 pad_oe port3 pin0", pad_oe, 32'h0100_F000);
        read_chk("R7 upper zero", 8'h0C, 32'h0000_0001);
        read_chk("R4 port2 untouched", 8'h28, 32'h0);

        // R6 synchronizer depth
        @(negedge clk);
        pad_in = 32'h5A00_00C3;
        bus_addr = 8'h30;
        @(posedge clk); #1;
        compare("R6 one edge", bus_rdata, 32'h0);
        @(posedge clk); #1;
        compare("R6 two edges", bus_rdata, 32'h0000_00C3);
        read_chk("R6 port3 input", 8'h3C, 32'h0000_005A);
        read_chk("R7 alias input read", 8'hBC, 32'h0000_005A);

        // R1 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        compare("R1 re-reset pad_oe", pad_oe, '0);
        compare("R1 re-reset pad_out", pad_out, '0);
        read_chk("R1 re-reset mode", 8'h04, 32'h0);
        read_chk("R1 re-reset dir", 8'h14, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule